// File: doc/BRIEF.md
# Packed SIMD Arithmetic Right Shifter

This block takes a 64-bit packed operand and shifts every lane right by one shared unsigned count. The vacated high bits of each lane take that lane's original sign bit. A mode input splits the operand into four 16-bit lanes or two 32-bit lanes. One datapath serves both widths: a single count decoder feeds a bank of narrow lane shifters and a bank of wide lane shifters, and the mode picks between them.

The count comes from one of two sources, chosen by a select input. The first is a full 64-bit register value. The second is an 8-bit immediate, which is zero-extended to 64 bits. Saturation is judged across all 64 bits of the count. Any count beyond the lane's largest shift fills the whole lane with its sign, including a count whose only set bits are far above the low byte.

Inputs are captured on a valid strobe. The result and an output valid appear on the next clock.

Top module: `packed_sar`

## Requirements
- R1: With `lane_mode`=0 (word), bits [16k+15:16k] of `result` for k=0..3 equal that 16-bit lane of `operand` shifted right arithmetically by the count, with the vacated bits equal to bit 16k+15 of `operand`. With a count of 2, lane 16'hD1C7 becomes 16'hF471 and lane 16'hFFFC becomes 16'hFFFF.
- R2: With `lane_mode`=1 (doubleword), bits [32k+31:32k] of `result` for k=0..1 equal that 32-bit lane shifted right arithmetically by the count, with the vacated bits equal to bit 32k+31 of `operand`.
- R3: With `cnt_src`=0 the count is the unsigned 64-bit `cnt_reg`. With `cnt_src`=1 the count is `cnt_imm` zero-extended to 64 bits, and `cnt_reg` has no effect.
- R4: In word mode, any count greater than 15 sets every bit of each lane to that lane's original sign bit. This covers immediates from 16 to 255 and register counts whose only set bits lie above bit 7 (for example 64'h1_0000_0000).
- R5: In doubleword mode, any count greater than 31 sets every bit of each lane to that lane's original sign bit.
- R6: A count of zero gives `result` equal to `operand` in both modes.
- R7: No bit crosses a lane boundary. A lane's result depends only on that lane's operand bits and the count.
- R8: `out_valid` is 1 in the cycle after a clock edge that saw `in_valid`=1, and 0 otherwise. `result` changes only on an edge that sees `in_valid`=1.
- R9: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operand, count and mode |
| lane_mode | input | 1 | 0 = four 16-bit lanes, 1 = two 32-bit lanes |
| cnt_src | input | 1 | 0 = count from `cnt_reg`, 1 = count from `cnt_imm` |
| operand | input | 64 | Packed value to shift |
| cnt_reg | input | 64 | Unsigned 64-bit register count |
| cnt_imm | input | 8 | Unsigned immediate count |
| out_valid | output | 1 | Result valid, one cycle after capture |
| result | output | 64 | Registered shifted result |

## Verification
Two behaviours can meet on one input:
- Saturation of the count and sign fill inside a lane.
- The boundary between lanes.

Operands are chosen so that the sign bit of one lane sits right next to the clear low bit of its upper neighbour. These operands are then driven with counts at the limit (15, 31), just beyond it (16, 32, 255), and with huge 64-bit counts. Each result is judged lane by lane against a reference that treats every lane in isolation. A bit that leaks across a boundary, or a saturation that ignores high count bits, therefore appears as a lane mismatch.

The same operand is also driven with the immediate source selected while `cnt_reg` holds a saturating value. This shows that the unused count source has no effect on the result.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic {
      LANE_WORD  = 1'b0,
      LANE_DWORD = 1'b1
   } lane_mode_e;

   typedef enum logic {
      CNT_FROM_REG = 1'b0,
      CNT_FROM_IMM = 1'b1
   } cnt_src_e;

   localparam int IMPL_OPERATOR = 0;
   localparam int IMPL_BARREL   = 1;
endpackage

// File: rtl/sar_count_unit.sv
module sar_count_unit #(
   parameter int CNT_W   = 64,
   parameter int IMM_W   = 8,
   parameter int NARROW_W = 16,
   parameter int WIDE_W  = 32,
   localparam int NARROW_LG = $clog2(NARROW_W),
   localparam int WIDE_LG   = $clog2(WIDE_W)
) (
   input  logic                 use_imm,
   input  logic [CNT_W-1:0]     cnt_reg,
   input  logic [IMM_W-1:0]     cnt_imm,
   output logic [WIDE_LG-1:0]   amount,
   output logic                 narrow_sat,
   output logic                 wide_sat
);
   logic [CNT_W-1:0] cnt_full;

   generate
      if (IMM_W > CNT_W) begin : g_bad_imm
         $error("sar_count_unit: IMM_W must not exceed CNT_W");
      end
      if (WIDE_LG >= CNT_W) begin : g_bad_cnt
         $error("sar_count_unit: CNT_W too narrow for the lane width");
      end
   endgenerate

   always_comb begin
      cnt_full = '0;
      if (use_imm) cnt_full[IMM_W-1:0] = cnt_imm;
      else         cnt_full = cnt_reg;
   end

   assign amount     = cnt_full[WIDE_LG-1:0];
   assign narrow_sat = |cnt_full[CNT_W-1:NARROW_LG];
   assign wide_sat   = |cnt_full[CNT_W-1:WIDE_LG];
endmodule

// File: rtl/sar_lane.sv
module sar_lane #(
   parameter int W    = 16,
   parameter int IMPL = 1,
   localparam int LG  = $clog2(W)
) (
   input  logic [W-1:0]  lane_in,
   input  logic [LG-1:0] amt,
   input  logic          sat,
   output logic [W-1:0]  lane_out
);
   logic         sgn;
   logic [W-1:0] shifted;

   assign sgn = lane_in[W-1];

   generate
      if (W < 2 || (1 << LG) != W) begin : g_bad_w
         $error("sar_lane: W must be a power of two of at least 2");
      end

      if (IMPL == sar_pkg::IMPL_OPERATOR) begin : g_op
         assign shifted = $unsigned($signed(lane_in) >>> amt);
      end else begin : g_barrel
         logic [W-1:0] stg [0:LG];
         assign stg[0] = lane_in;
         for (genvar k = 0; k < LG; k++) begin : g_stage
            localparam int D = 1 << k;
            assign stg[k+1] = amt[k] ? {{D{sgn}}, stg[k][W-1:D]} : stg[k];
         end
         assign shifted = stg[LG];
      end
   endgenerate

   assign lane_out = sat ? {W{sgn}} : shifted;

   always_comb begin
      AST_SIGN_KEPT: assert (lane_out[W-1] == lane_in[W-1]); // R1
   end
endmodule

// File: rtl/packed_sar.sv
module packed_sar #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 16,
   parameter int WIDE_W   = 32,
   parameter int IMM_W    = 8,
   parameter int IMPL     = sar_pkg::IMPL_BARREL,
   localparam int N_NARROW  = DATA_W / NARROW_W,
   localparam int N_WIDE    = DATA_W / WIDE_W,
   localparam int NARROW_LG = $clog2(NARROW_W),
   localparam int WIDE_LG   = $clog2(WIDE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              lane_mode,
   input  logic              cnt_src,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] cnt_reg,
   input  logic [IMM_W-1:0]  cnt_imm,
   output logic              out_valid,
   output logic [DATA_W-1:0] result
);
   import sar_pkg::*;

   logic [WIDE_LG-1:0] amount;
   logic               narrow_sat;
   logic               wide_sat;
   logic [DATA_W-1:0]  narrow_res;
   logic [DATA_W-1:0]  wide_res;
   logic [DATA_W-1:0]  next_res;

   generate
      if (DATA_W % WIDE_W != 0) begin : g_bad_data
         $error("packed_sar: DATA_W must be a multiple of WIDE_W");
      end
      if (WIDE_W != 2 * NARROW_W) begin : g_bad_ratio
         $error("packed_sar: WIDE_W must be twice NARROW_W");
      end
   endgenerate

   sar_count_unit #(
      .CNT_W(DATA_W), .IMM_W(IMM_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
   ) u_cnt (
      .use_imm(cnt_src == CNT_FROM_IMM),
      .cnt_reg(cnt_reg),
      .cnt_imm(cnt_imm),
      .amount(amount),
      .narrow_sat(narrow_sat),
      .wide_sat(wide_sat)
   );

   generate
      for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
         sar_lane #(.W(NARROW_W), .IMPL(IMPL)) u_lane (
            .lane_in(operand[i*NARROW_W +: NARROW_W]),
            .amt(amount[NARROW_LG-1:0]),
            .sat(narrow_sat),
            .lane_out(narrow_res[i*NARROW_W +: NARROW_W])
         );
      end
      for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
         sar_lane #(.W(WIDE_W), .IMPL(IMPL)) u_lane (
            .lane_in(operand[j*WIDE_W +: WIDE_W]),
            .amt(amount),
            .sat(wide_sat),
            .lane_out(wide_res[j*WIDE_W +: WIDE_W])
         );
      end
   endgenerate

   assign next_res = (lane_mode == LANE_DWORD) ? wide_res : narrow_res;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R8
   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R8
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result)); // R8
   AST_TOP_SIGN: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> result[DATA_W-1] == $past(operand[DATA_W-1])); // R7
   AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cnt_src == CNT_FROM_REG && cnt_reg == '0)
      |=> result == $past(operand)); // R6
endmodule

// File: tb/sim_packed_sar.sv
module sim_packed_sar;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        lane_mode;
   logic        cnt_src;
   logic [63:0] operand;
   logic [63:0] cnt_reg;
   logic [7:0]  cnt_imm;
   logic        out_valid;
   logic [63:0] result;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   packed_sar u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .lane_mode(lane_mode),
      .cnt_src(cnt_src), .operand(operand), .cnt_reg(cnt_reg),
      .cnt_imm(cnt_imm), .out_valid(out_valid), .result(result)
   );

   function automatic logic [63:0] ref_sar(input logic [63:0] op,
                                           input logic md,
                                           input logic [63:0] cnt);
      logic [63:0] r;
      r = '0;
      if (!md) begin
         for (int i = 0; i < 4; i++) begin
            logic signed [15:0] x;
            x = op[i*16 +: 16];
            r[i*16 +: 16] = (cnt > 64'd15) ? {16{x[15]}} : 16'(x >>> cnt[3:0]);
         end
      end else begin
         for (int i = 0; i < 2; i++) begin
            logic signed [31:0] x;
            x = op[i*32 +: 32];
            r[i*32 +: 32] = (cnt > 64'd31) ? {32{x[31]}} : 32'(x >>> cnt[4:0]);
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // Drive one operation, then check the result, the valid flag and the hold.
   task automatic run_op(input string req, input logic md, input logic src,
                         input logic [63:0] op, input logic [63:0] creg,
                         input logic [7:0] cimm, input logic [63:0] exp);
      @(negedge clk);
      lane_mode = md; cnt_src = src; operand = op;
      cnt_reg = creg; cnt_imm = cimm; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      operand  = ~op;
      check(req, result, exp);
      check("R8 valid", {63'd0, out_valid}, 64'd1);
      @(negedge clk);
      check("R8 hold", result, exp);
      check("R8 idle", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; lane_mode = 1'b0; cnt_src = 1'b0;
      operand = '1; cnt_reg = '0; cnt_imm = '0;
      repeat (3) @(negedge clk);
      check("R9 result", result, 64'd0);
      check("R9 valid", {63'd0, out_valid}, 64'd0);
      rst = 1'b0;
   endtask

   task automatic t_word_example();
      logic [63:0] op;
      op = 64'hFFFC_D1C7_7FFF_8001;
      run_op("R1 example", 1'b0, 1'b0, op, 64'd2, 8'd0,
             {16'hFFFF, 16'hF471, 16'h1FFF, 16'hE000});
   endtask

   task automatic t_word_counts();
      logic [63:0] ops [3];
      logic [63:0] cnts [7];
      ops[0] = 64'h8000_7FFF_8001_0001;
      ops[1] = 64'h1234_ABCD_F00F_0FF0;
      ops[2] = 64'h7FFF_FFFF_0000_8000;
      cnts[0] = 64'd0; cnts[1] = 64'd1; cnts[2] = 64'd15; cnts[3] = 64'd16;
      cnts[4] = 64'd31; cnts[5] = 64'd32; cnts[6] = 64'd255;
      foreach (ops[a]) foreach (cnts[b]) begin
         if (cnts[b] == 0)
            run_op("R6 word zero", 1'b0, 1'b0, ops[a], 64'd0, 8'd0, ops[a]);
         else if (cnts[b] > 15)
            run_op("R4 word sat", 1'b0, 1'b0, ops[a], cnts[b], 8'd0,
                   ref_sar(ops[a], 1'b0, cnts[b]));
         else
            run_op("R1 word shift", 1'b0, 1'b0, ops[a], cnts[b], 8'd0,
                   ref_sar(ops[a], 1'b0, cnts[b]));
      end
   endtask

   task automatic t_dword_counts();
      logic [63:0] ops [3];
      logic [63:0] cnts [7];
      ops[0] = 64'h8000_0000_7FFF_FFFF;
      ops[1] = 64'h0000_8000_DEAD_BEEF;
      ops[2] = 64'hC001_0000_0001_8000;
      cnts[0] = 64'd0; cnts[1] = 64'd1; cnts[2] = 64'd15; cnts[3] = 64'd16;
      cnts[4] = 64'd31; cnts[5] = 64'd32; cnts[6] = 64'd255;
      foreach (ops[a]) foreach (cnts[b]) begin
         if (cnts[b] == 0)
            run_op("R6 dword zero", 1'b1, 1'b0, ops[a], 64'd0, 8'd0, ops[a]);
         else if (cnts[b] > 31)
            run_op("R5 dword sat", 1'b1, 1'b0, ops[a], cnts[b], 8'd0,
                   ref_sar(ops[a], 1'b1, cnts[b]));
         else
            run_op("R2 dword shift", 1'b1, 1'b0, ops[a], cnts[b], 8'd0,
                   ref_sar(ops[a], 1'b1, cnts[b]));
      end
   endtask

   task automatic t_big_counts();
      logic [63:0] op;
      op = 64'h8765_4321_F0F0_0F0F;
      run_op("R4 high bit", 1'b0, 1'b0, op, 64'h1_0000_0000, 8'd0,
             {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000});
      run_op("R4 top bit", 1'b0, 1'b0, op, 64'h8000_0000_0000_0001, 8'd0,
             {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000});
      run_op("R5 high bit", 1'b1, 1'b0, op, 64'h0000_0100_0000_0003, 8'd0,
             {32'hFFFF_FFFF, 32'hFFFF_FFFF});
      run_op("R5 all ones", 1'b1, 1'b0, 64'h7000_0000_8000_0000, '1, 8'd0,
             {32'h0000_0000, 32'hFFFF_FFFF});
   endtask

   task automatic t_immediate();
      logic [63:0] op;
      op = 64'hA5A5_5A5A_8000_7FFF;
      run_op("R3 imm shift", 1'b0, 1'b1, op, 64'h1_0000_0000, 8'd3,
             ref_sar(op, 1'b0, 64'd3));
      run_op("R3 imm sat", 1'b0, 1'b1, op, 64'd0, 8'd16,
             ref_sar(op, 1'b0, 64'd16));
      run_op("R3 imm 255", 1'b1, 1'b1, op, 64'd1, 8'd255,
             ref_sar(op, 1'b1, 64'd255));
      run_op("R3 imm dword", 1'b1, 1'b1, op, '1, 8'd31,
             ref_sar(op, 1'b1, 64'd31));
      run_op("R6 imm zero", 1'b1, 1'b1, op, 64'd40, 8'd0, op);
   endtask

   task automatic t_lane_isolation();
      run_op("R7 word edge", 1'b0, 1'b0, 64'h0000_FFFF_0000_FFFF, 64'd4, 8'd0,
             64'h0000_FFFF_0000_FFFF);
      run_op("R7 word carry", 1'b0, 1'b0, 64'h0001_0001_0001_0001, 64'd1, 8'd0,
             64'd0);
      run_op("R7 dword edge", 1'b1, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'd8, 8'd0,
             64'h0000_0000_FFFF_FFFF);
      run_op("R7 dword mid", 1'b1, 1'b0, 64'h0001_0000_8000_0000, 64'd16, 8'd0,
             64'h0000_0001_FFFF_8000);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_word_example();
      t_word_counts();
      t_dword_counts();
      t_big_counts();
      t_immediate();
      t_lane_isolation();
      finish_run();
   end
endmodule